// File: doc/BRIEF.md
# Serial Flash Link Mode Controller

This block sits between a graphics engine and an external serial NOR flash and owns the link to it. After reset it probes the bus for a device and settles into one of four host-visible modes: init, detached, basic or full. A host steers it with a small set of commands. It can attach, detach or request full speed. While the link is detached, the host can also deselect the device and shift single bytes out or in by hand, which gives software direct byte-level control of the serial bus.

The engine has its own read port. Requests on it are granted only in full mode. A granted read runs a complete quad-output fetch and returns one byte. The block drives chip select, the serial clock and four data lines with per-line output enables. Transfers use single-bit SPI mode 0, except the data phase of an engine read, which moves a nibble per clock. When the probe finds nothing, every flash output is held low.

Top module: `flash_link_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after release, link_mode reads 0 (init) and host_busy is 1. The probe then starts without any host command.
- R2: The probe lowers fl_cs_n and sends opcode 0x9F on fl_io_o[0], MSB first. It then reads one byte from fl_io_i[1]. A byte of 0x00 or 0xFF gives link_mode 1 (detached), and any other byte gives link_mode 2 (basic). host_busy then falls.
- R3: After a failed probe, fl_cs_n and fl_sck are 0, fl_io_o is 4'h0 and fl_io_oe is 4'hF. These stay until a host command is accepted.
- R4: Command code 2 (full speed) in basic repeats the ID read. A valid byte gives link_mode 3 (full). An invalid byte leaves link_mode at 2. Either way host_done pulses.
- R5: Command code 2 in detached or full pulses host_done and leaves link_mode unchanged.
- R6: Command code 1 (detach) is taken in any mode whenever the block is idle. It sets link_mode 1, raises fl_cs_n and pulses host_done.
- R7: Command codes 3 (deselect), 4 (send byte) and 5 (receive byte) outside detached pulse host_err. They leave link_mode and fl_cs_n unchanged.
- R8: In detached mode:
  - Code 4 shifts host_arg out MSB first on fl_io_o[0] and leaves fl_cs_n low.
  - Code 5 clocks 8 bits in from fl_io_i[1] while sending zeros, then shows the byte on host_rdata with host_done.
  - Code 3 raises fl_cs_n.
- R9: Command code 0 (attach) in detached sets link_mode 2 with fl_cs_n high. In any other mode it pulses host_err.
- R10: rd_gnt pulses only in full mode while idle. The read that follows has these phases, in order:
  - opcode 0x6B, single-bit;
  - the ADDR_W-bit address, MSB first;
  - 8 dummy clocks with all lines released;
  - one byte from fl_io_i[3:0], high nibble first, returned with a one-cycle rd_valid.
- R11: Clocking follows SPI mode 0:
  - fl_sck is low whenever fl_cs_n is high.
  - The clock half-period is HALF_BASIC cycles outside full mode and one cycle in full mode.
  - Data is sampled on rising fl_sck.
- R12: host_busy is high from acceptance of a multi-cycle command until its result pulse. Commands and reads are taken only while idle, and a host command wins over rd_req in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_valid | input | 1 | host command strobe, taken when idle |
| host_op | input | 3 | command code |
| host_arg | input | 8 | byte to send for code 4 |
| host_busy | output | 1 | a command, probe or read is running |
| host_done | output | 1 | command completed |
| host_err | output | 1 | command rejected |
| host_rdata | output | 8 | byte from the last receive command |
| link_mode | output | 2 | 0 init, 1 detached, 2 basic, 3 full |
| rd_req | input | 1 | engine read request |
| rd_addr | input | ADDR_W | engine read byte address |
| rd_gnt | output | 1 | read request accepted |
| rd_valid | output | 1 | read data strobe |
| rd_data | output | 8 | read data |
| fl_cs_n | output | 1 | flash chip select, active low |
| fl_sck | output | 1 | flash serial clock |
| fl_io_o | output | 4 | flash data outputs |
| fl_io_oe | output | 4 | flash data output enables |
| fl_io_i | input | 4 | flash data inputs |

## Verification
The hardest situation to reach is the no-device state where every pin is forced low. Close behind it is a full-speed request that fails because the device has vanished after a good probe. The bench's flash model has a presence switch. Clearing it makes every data line float high, so any ID read returns 0xFF. Resetting with the switch cleared gives the failed probe. Clearing it while in basic mode and then asking for full speed exercises the failed promotion. The model also decodes the quad read from its own count of clock edges, so the order of address, dummy and nibble phases is checked against a device view rather than the RTL.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef enum logic [1:0] {
        MODE_INIT     = 2'd0,
        MODE_DETACHED = 2'd1,
        MODE_BASIC    = 2'd2,
        MODE_FULL     = 2'd3
    } link_mode_e;

    typedef enum logic [2:0] {
        OP_ATTACH = 3'd0,
        OP_DETACH = 3'd1,
        OP_FAST   = 3'd2,
        OP_DESEL  = 3'd3,
        OP_TX     = 3'd4,
        OP_RX     = 3'd5
    } host_op_e;

    typedef enum logic [2:0] {
        Q_IDLE,
        Q_ID_OP,
        Q_ID_BYTE,
        Q_HOST_XFER,
        Q_RD_OP,
        Q_RD_ADDR,
        Q_RD_DUMMY,
        Q_RD_DATA
    } seq_e;

    localparam logic [7:0] ID_OPCODE = 8'h9F;

    function automatic logic id_is_device(input logic [7:0] b);
        return (b != 8'h00) && (b != 8'hFF);
    endfunction

endpackage

// File: rtl/flk_shifter.sv
module flk_shifter #(
    parameter int HALF_BASIC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       quad,
    input  logic       drive,
    input  logic       fast,
    input  logic [3:0] io_i,
    output logic       busy,
    output logic       done,
    output logic       sck,
    output logic [7:0] rx_byte,
    output logic [3:0] io_o,
    output logic [3:0] io_oe
);
    localparam int CW = (HALF_BASIC < 2) ? 1 : $clog2(HALF_BASIC);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          sck;
        logic          quad;
        logic          drive;
        logic          fast;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic [3:0]    left;
        logic [CW-1:0] div;
    } shf_t;

    shf_t q, d;
    logic [CW-1:0] lim_m1;

    always_comb begin
        lim_m1 = q.fast ? '0 : CW'(HALF_BASIC - 1);
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.sck   = 1'b0;
                d.sh    = tx_byte;
                d.rx    = 8'h00;
                d.quad  = quad;
                d.drive = drive;
                d.fast  = fast;
                d.left  = quad ? 4'd2 : 4'd8;
                d.div   = '0;
            end
        end else if (q.div == lim_m1) begin
            d.div = '0;
            d.sck = !q.sck;
            if (!q.sck) begin
                d.rx = q.quad ? {q.rx[3:0], io_i} : {q.rx[6:0], io_i[1]};
            end else begin
                d.left = q.left - 4'd1;
                if (q.left == 4'd1) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.sh = q.quad ? {q.sh[3:0], 4'h0} : {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            d.div = q.div + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (!q.busy) begin
            io_o  = 4'b1100;
            io_oe = 4'b1101;
        end else if (!q.drive) begin
            io_o  = 4'b0000;
            io_oe = 4'b0000;
        end else if (q.quad) begin
            io_o  = q.sh[7:4];
            io_oe = 4'b1111;
        end else begin
            io_o  = {2'b11, 1'b0, q.sh[7]};
            io_oe = 4'b1101;
        end
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign sck     = q.sck;
    assign rx_byte = q.rx;

    p_clk_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sck);

endmodule

// File: rtl/flk_sequencer.sv
module flk_sequencer
    import flk_pkg::*;
#(
    parameter int         ADDR_W  = 24,
    parameter logic [7:0] READ_OP = 8'h6B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [2:0]        host_op,
    input  logic [7:0]        host_arg,
    output logic              host_busy,
    output logic              host_done,
    output logic              host_err,
    output logic [7:0]        host_rdata,
    output logic [1:0]        mode,
    output logic              nodev,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_gnt,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              cs_n,
    output logic              eng_start,
    output logic [7:0]        eng_tx,
    output logic              eng_quad,
    output logic              eng_drive,
    output logic              eng_fast,
    input  logic              eng_done,
    input  logic [7:0]        eng_rx
);
    localparam int ABYTES = ADDR_W / 8;
    localparam int AW     = $clog2(ABYTES + 1);

    typedef struct packed {
        seq_e          seq;
        link_mode_e    mode;
        logic          cs_n;
        logic          issued;
        logic          probe;
        logic          nodev;
        logic          rx_op;
        logic [7:0]    hbyte;
        logic [ADDR_W-1:0] addr;
        logic [AW-1:0] abyte;
        logic          done;
        logic          err;
        logic [7:0]    rsp;
        logic          gnt;
        logic          rvalid;
        logic [7:0]    rdata;
    } seq_t;

    seq_t q, d;
    logic phase_end;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        d.gnt     = 1'b0;
        d.rvalid  = 1'b0;
        eng_start = 1'b0;
        eng_tx    = 8'h00;
        eng_drive = 1'b1;
        eng_quad  = 1'b0;
        eng_fast  = (q.mode == MODE_FULL);
        phase_end = q.issued && eng_done;

        if (q.seq != Q_IDLE && !q.issued) begin
            eng_start = 1'b1;
            d.issued  = 1'b1;
        end
        if (phase_end) d.issued = 1'b0;

        case (q.seq)
            Q_IDLE: begin
                if (host_valid) begin
                    case (host_op)
                        OP_ATTACH: begin
                            if (q.mode == MODE_DETACHED) begin
                                d.mode  = MODE_BASIC;
                                d.cs_n  = 1'b1;
                                d.nodev = 1'b0;
                                d.done  = 1'b1;
                            end else d.err = 1'b1;
                        end
                        OP_DETACH: begin
                            d.mode  = MODE_DETACHED;
                            d.cs_n  = 1'b1;
                            d.nodev = 1'b0;
                            d.done  = 1'b1;
                        end
                        OP_FAST: begin
                            if (q.mode == MODE_BASIC) begin
                                d.seq   = Q_ID_OP;
                                d.probe = 1'b1;
                            end else d.done = 1'b1;
                        end
                        OP_DESEL: begin
                            if (q.mode == MODE_DETACHED) begin
                                d.cs_n  = 1'b1;
                                d.nodev = 1'b0;
                                d.done  = 1'b1;
                            end else d.err = 1'b1;
                        end
                        OP_TX, OP_RX: begin
                            if (q.mode == MODE_DETACHED) begin
                                d.seq   = Q_HOST_XFER;
                                d.cs_n  = 1'b0;
                                d.nodev = 1'b0;
                                d.rx_op = (host_op == OP_RX);
                                d.hbyte = (host_op == OP_TX) ? host_arg : 8'h00;
                            end else d.err = 1'b1;
                        end
                        default: d.err = 1'b1;
                    endcase
                end else if (rd_req && q.mode == MODE_FULL) begin
                    d.gnt   = 1'b1;
                    d.seq   = Q_RD_OP;
                    d.cs_n  = 1'b0;
                    d.addr  = rd_addr;
                    d.abyte = '0;
                end
            end
            Q_ID_OP: begin
                eng_tx = ID_OPCODE;
                d.cs_n = 1'b0;
                if (phase_end) d.seq = Q_ID_BYTE;
            end
            Q_ID_BYTE: begin
                if (phase_end) begin
                    d.seq  = Q_IDLE;
                    d.cs_n = 1'b1;
                    if (q.probe) begin
                        d.probe = 1'b0;
                        d.done  = 1'b1;
                        d.mode  = id_is_device(eng_rx) ? MODE_FULL : MODE_BASIC;
                    end else begin
                        d.mode  = id_is_device(eng_rx) ? MODE_BASIC : MODE_DETACHED;
                        d.nodev = !id_is_device(eng_rx);
                    end
                end
            end
            Q_HOST_XFER: begin
                eng_tx = q.hbyte;
                if (phase_end) begin
                    d.seq  = Q_IDLE;
                    d.done = 1'b1;
                    if (q.rx_op) d.rsp = eng_rx;
                end
            end
            Q_RD_OP: begin
                eng_tx = READ_OP;
                if (phase_end) d.seq = Q_RD_ADDR;
            end
            Q_RD_ADDR: begin
                eng_tx = q.addr[ADDR_W-1 -: 8];
                if (phase_end) begin
                    d.addr  = q.addr << 8;
                    d.abyte = q.abyte + AW'(1);
                    if (q.abyte == AW'(ABYTES - 1)) d.seq = Q_RD_DUMMY;
                end
            end
            Q_RD_DUMMY: begin
                eng_drive = 1'b0;
                if (phase_end) d.seq = Q_RD_DATA;
            end
            Q_RD_DATA: begin
                eng_drive = 1'b0;
                eng_quad  = 1'b1;
                if (phase_end) begin
                    d.seq    = Q_IDLE;
                    d.cs_n   = 1'b1;
                    d.rvalid = 1'b1;
                    d.rdata  = eng_rx;
                end
            end
            default: d.seq = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.seq  <= Q_ID_OP;
            q.mode <= MODE_INIT;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign host_busy  = (q.seq != Q_IDLE);
    assign host_done  = q.done;
    assign host_err   = q.err;
    assign host_rdata = q.rsp;
    assign mode       = q.mode;
    assign nodev      = q.nodev;
    assign rd_gnt     = q.gnt;
    assign rd_valid   = q.rvalid;
    assign rd_data    = q.rdata;
    assign cs_n       = q.cs_n;

    p_init_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_INIT && mode != MODE_INIT) |->
        (mode == MODE_BASIC || mode == MODE_DETACHED));

    p_full_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FULL && $past(mode) != MODE_FULL) |-> $past(mode) == MODE_BASIC);

    p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (mode == $past(mode) && cs_n == $past(cs_n)));

    p_gnt_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |-> $past(mode) == MODE_FULL);

    p_attach_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BASIC && $past(mode) == MODE_DETACHED) |->
        ($past(host_valid) && $past(host_op) == OP_ATTACH));

    p_one_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_done, host_err, rd_valid}));

endmodule

// File: rtl/flk_pin_mux.sv
module flk_pin_mux (
    input  logic       force_low,
    input  logic       cs_n,
    input  logic       sck,
    input  logic [3:0] io_o,
    input  logic [3:0] io_oe,
    output logic       pin_cs_n,
    output logic       pin_sck,
    output logic [3:0] pin_io_o,
    output logic [3:0] pin_io_oe
);
    always_comb begin
        if (force_low) begin
            pin_cs_n  = 1'b0;
            pin_sck   = 1'b0;
            pin_io_o  = 4'h0;
            pin_io_oe = 4'hF;
        end else begin
            pin_cs_n  = cs_n;
            pin_sck   = sck;
            pin_io_o  = io_o;
            pin_io_oe = io_oe;
        end
    end
endmodule

// File: rtl/flash_link_ctrl.sv
module flash_link_ctrl
    import flk_pkg::*;
#(
    parameter int         ADDR_W     = 24,
    parameter int         HALF_BASIC = 2,
    parameter logic [7:0] READ_OP    = 8'h6B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [2:0]        host_op,
    input  logic [7:0]        host_arg,
    output logic              host_busy,
    output logic              host_done,
    output logic              host_err,
    output logic [7:0]        host_rdata,
    output logic [1:0]        link_mode,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_gnt,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              fl_cs_n,
    output logic              fl_sck,
    output logic [3:0]        fl_io_o,
    output logic [3:0]        fl_io_oe,
    input  logic [3:0]        fl_io_i
);
    logic       eng_start, eng_quad, eng_drive, eng_fast;
    logic       eng_busy, eng_done, eng_sck;
    logic [7:0] eng_tx, eng_rx;
    logic [3:0] eng_io_o, eng_io_oe;
    logic       seq_cs_n, nodev;

    flk_sequencer #(.ADDR_W(ADDR_W), .READ_OP(READ_OP)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_op(host_op), .host_arg(host_arg),
        .host_busy(host_busy), .host_done(host_done), .host_err(host_err),
        .host_rdata(host_rdata), .mode(link_mode), .nodev(nodev),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
        .rd_valid(rd_valid), .rd_data(rd_data), .cs_n(seq_cs_n),
        .eng_start(eng_start), .eng_tx(eng_tx), .eng_quad(eng_quad),
        .eng_drive(eng_drive), .eng_fast(eng_fast),
        .eng_done(eng_done), .eng_rx(eng_rx)
    );

    flk_shifter #(.HALF_BASIC(HALF_BASIC)) u_shf (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx),
        .quad(eng_quad), .drive(eng_drive), .fast(eng_fast), .io_i(fl_io_i),
        .busy(eng_busy), .done(eng_done), .sck(eng_sck), .rx_byte(eng_rx),
        .io_o(eng_io_o), .io_oe(eng_io_oe)
    );

    flk_pin_mux u_pins (
        .force_low(link_mode == MODE_DETACHED && nodev),
        .cs_n(seq_cs_n), .sck(eng_sck), .io_o(eng_io_o), .io_oe(eng_io_oe),
        .pin_cs_n(fl_cs_n), .pin_sck(fl_sck), .pin_io_o(fl_io_o), .pin_io_oe(fl_io_oe)
    );

    p_sck_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cs_n |-> !fl_sck);

    p_shift_needs_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !fl_cs_n);

endmodule

// File: tb/sim_flash_link_ctrl.sv
`timescale 1ns/1ps
module sim_flash_link_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_valid = 1'b0;
    logic [2:0] host_op = 3'd0;
    logic [7:0] host_arg = 8'h00;
    logic host_busy, host_done, host_err;
    logic [7:0] host_rdata;
    logic [1:0] link_mode;
    logic rd_req = 1'b0;
    logic [23:0] rd_addr = 24'h0;
    logic rd_gnt, rd_valid;
    logic [7:0] rd_data;
    logic fl_cs_n, fl_sck;
    logic [3:0] fl_io_o, fl_io_oe;
    logic [3:0] dev_io = 4'hF;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    localparam logic [7:0] DEV_ID = 8'hC2;

    always #4 clk = ~clk;

    flash_link_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_op(host_op),
        .host_arg(host_arg), .host_busy(host_busy), .host_done(host_done),
        .host_err(host_err), .host_rdata(host_rdata), .link_mode(link_mode),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_valid(rd_valid),
        .rd_data(rd_data), .fl_cs_n(fl_cs_n), .fl_sck(fl_sck), .fl_io_o(fl_io_o),
        .fl_io_oe(fl_io_oe), .fl_io_i(dev_io)
    );

    // flash device model
    bit dev_present = 0;
    int n = 0;
    logic [31:0] sh_in = 0;
    logic [7:0] opc = 0;
    logic [23:0] maddr = 0;
    logic [7:0] mbyte;

    always @(posedge fl_cs_n) begin
        n = 0; opc = 8'h00; dev_io = 4'hF;
    end
    always @(posedge fl_sck) if (!fl_cs_n) begin
        sh_in = {sh_in[30:0], fl_io_o[0]};
        n = n + 1;
        if (n == 8) opc = sh_in[7:0];
        if (n == 32) maddr = sh_in[23:0];
    end
    always @(negedge fl_sck) if (!fl_cs_n) begin
        if (!dev_present) dev_io = 4'hF;
        else if (opc == 8'h9F && n >= 8) dev_io[1] = DEV_ID[7 - ((n - 8) % 8)];
        else if (opc == 8'h6B && n >= 40) begin
            mbyte = maddr[7:0] ^ 8'h5A;
            if (n == 40) dev_io = mbyte[7:4];
            else if (n == 41) dev_io = mbyte[3:0];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: 0 done, 1 err, 2 read data
    int         q_kind[$];
    logic [7:0] q_data[$];
    bit         q_chk[$];
    string      q_req[$];

    always @(negedge clk) if (rst_n && (host_done || host_err || rd_valid)) begin
        int k;
        logic [7:0] dv;
        k  = rd_valid ? 2 : (host_err ? 1 : 0);
        dv = rd_valid ? rd_data : host_rdata;
        if (q_kind.size() == 0) check(0, "R12 unexpected result", k, 99);
        else begin
            int ek; logic [7:0] ed; bit ec; string er;
            ek = q_kind.pop_front(); ed = q_data.pop_front();
            ec = q_chk.pop_front();  er = q_req.pop_front();
            check(k == ek, er, k, ek);
            if (ec) check(dv == ed, er, dv, ed);
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 2000 && (host_busy || q_kind.size() != 0); i++) @(negedge clk);
    endtask

    task automatic host_cmd(input logic [2:0] op, input logic [7:0] arg, input int kind,
                            input logic [7:0] data, input bit chk, input string req);
        wait_idle();
        q_kind.push_back(kind); q_data.push_back(data);
        q_chk.push_back(chk);   q_req.push_back(req);
        host_op = op; host_arg = arg; host_valid = 1'b1;
        @(negedge clk);
        host_valid = 1'b0;
        wait_idle();
    endtask

    task automatic eng_read(input logic [23:0] a, input string req);
        wait_idle();
        q_kind.push_back(2); q_data.push_back(a[7:0] ^ 8'h5A);
        q_chk.push_back(1);  q_req.push_back(req);
        rd_addr = a; rd_req = 1'b1;
        for (int i = 0; i < 100 && !rd_gnt; i++) @(negedge clk);
        rd_req = 1'b0;
        wait_idle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(link_mode == 2'd0 && host_busy, "R1 in reset", link_mode, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(link_mode == 2'd0 && host_busy, "R1 after release", {host_busy, link_mode}, 3'b100);
        wait_idle();
    endtask

    initial begin
        // absent device
        dev_present = 0;
        do_reset();
        check(link_mode == 2'd1, "R2 no device gives detached", link_mode, 1);
        check(fl_cs_n == 0 && fl_sck == 0 && fl_io_o == 4'h0 && fl_io_oe == 4'hF,
              "R3 pins low", {fl_cs_n, fl_sck, fl_io_o, fl_io_oe}, 10'h00F);
        repeat (5) @(negedge clk);
        check(fl_cs_n == 0 && fl_io_oe == 4'hF, "R3 pins held low", {fl_cs_n, fl_io_oe}, 5'h0F);
        host_cmd(3'd3, 8'h00, 0, 8'h00, 0, "R8 deselect done");
        check(fl_cs_n == 1 && fl_sck == 0, "R3 release by host cmd", fl_cs_n, 1);

        // present device
        dev_present = 1;
        do_reset();
        check(link_mode == 2'd2, "R2 device gives basic", link_mode, 2);
        check(fl_cs_n == 1 && fl_sck == 0, "R11 idle clock low", {fl_cs_n, fl_sck}, 2'b10);

        rd_req = 1'b1; rd_addr = 24'h000001;
        begin
            int g = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); if (rd_gnt) g++; end
            check(g == 0, "R10 no grant in basic", g, 0);
        end
        rd_req = 1'b0;

        host_cmd(3'd4, 8'h55, 1, 8'h00, 0, "R7 tx rejected in basic");
        check(link_mode == 2'd2 && fl_cs_n == 1, "R7 state kept", {link_mode, fl_cs_n}, 3'b101);
        host_cmd(3'd0, 8'h00, 1, 8'h00, 0, "R9 attach rejected in basic");

        dev_present = 0;
        host_cmd(3'd2, 8'h00, 0, 8'h00, 0, "R4 failed probe done");
        check(link_mode == 2'd2, "R4 failed probe stays basic", link_mode, 2);
        dev_present = 1;
        host_cmd(3'd2, 8'h00, 0, 8'h00, 0, "R4 probe done");
        check(link_mode == 2'd3, "R4 full mode", link_mode, 3);

        eng_read(24'h000123, "R10 read 000123");
        eng_read(24'hABCDF0, "R10 read ABCDF0");
        check(fl_cs_n == 1 && fl_sck == 0, "R11 idle after read", {fl_cs_n, fl_sck}, 2'b10);

        host_cmd(3'd2, 8'h00, 0, 8'h00, 0, "R5 fast in full");
        check(link_mode == 2'd3, "R5 full kept", link_mode, 3);

        host_cmd(3'd1, 8'h00, 0, 8'h00, 0, "R6 detach done");
        check(link_mode == 2'd1 && fl_cs_n == 1, "R6 detached", {link_mode, fl_cs_n}, 3'b011);
        host_cmd(3'd2, 8'h00, 0, 8'h00, 0, "R5 fast in detached");
        check(link_mode == 2'd1, "R5 detached kept", link_mode, 1);

        rd_req = 1'b1; rd_addr = 24'h000002;
        begin
            int g = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); if (rd_gnt) g++; end
            check(g == 0, "R6 no grant when detached", g, 0);
        end
        rd_req = 1'b0;

        // manual transfer, busy observed after acceptance
        wait_idle();
        q_kind.push_back(0); q_data.push_back(8'h00); q_chk.push_back(0); q_req.push_back("R8 tx done");
        host_op = 3'd4; host_arg = 8'h9F; host_valid = 1'b1;
        @(negedge clk);
        host_valid = 1'b0;
        check(host_busy == 1, "R12 busy during tx", host_busy, 1);
        wait_idle();
        check(fl_cs_n == 0, "R8 cs held low after tx", fl_cs_n, 0);
        host_cmd(3'd5, 8'h00, 0, DEV_ID, 1, "R8 rx returns id");
        host_cmd(3'd3, 8'h00, 0, 8'h00, 0, "R8 deselect");
        check(fl_cs_n == 1, "R8 cs high after deselect", fl_cs_n, 1);

        host_cmd(3'd0, 8'h00, 0, 8'h00, 0, "R9 attach done");
        check(link_mode == 2'd2 && fl_cs_n == 1, "R9 basic after attach", {link_mode, fl_cs_n}, 3'b101);

        repeat (5) @(negedge clk);
        check(q_kind.size() == 0, "R12 all results seen", q_kind.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule